// File: doc/BRIEF.md
# Cluster Responder Resolution Unit

This block sits beside a square grid of single-bit processing elements and condenses their response flags into the results that the controlling scalar processor reads. Each element presents one response bit. From the full set of bits the unit produces a registered some/none flag, a registered count of how many elements respond, and the registered linear address of the responder with the lowest address. The address output is signed and reads -1 when nothing responds.

The lowest address is found in two stages. A priority encoder over per-row OR terms picks the first row that holds a responder. Only that row's bits go to a second priority encoder, which picks the first column. The count comes from a binary adder tree, and the some/none flag comes from a separate OR reduction.

The unit also models the row and column mask lines that run across the grid. A line in a direction the controller drives reads back the driven value and gates the elements on it. A line in a direction the controller leaves undriven reads the wired-OR of the responses of the elements that are still selected on it. Driving a single column line and leaving the rows undriven therefore returns that whole column in parallel on the row lines. The element-select outputs give the grid the same gating.

Top module: `resp_resolver`

## Requirements
- R1: `any_o` is 1 exactly when at least one bit of `resp_i` was set at the previous rising clock edge.
- R2: `count_o` equals the number of set bits of `resp_i` at the previous rising clock edge, from 0 to N*N inclusive.
- R3: `first_addr_o` is the lowest index of a set bit of `resp_i` at the previous rising edge, as a two's-complement value. It reads -1 (all ones) when no bit was set.
- R4: Element (row r, column c) drives bit r*N+c of `resp_i` and has the address r*N+c. Bit r of the row lines and bit c of the column lines belong to that element.
- R5: The row of the reported address is the lowest row that holds any responder, even when a later row has a responder in a lower column.
- R6: While `rst_n` is low, `any_o` is 0, `count_o` is 0 and `first_addr_o` is -1. After reset the outputs in R1 to R3 follow the inputs with a latency of exactly one clock.
- R7: When a direction's enable (`row_oe_i` or `col_oe_i`) is 0, bit k of that direction's lines is the OR of the responses of the elements on line k whose select output (R9) is 1. This read is combinational.
- R8: When a direction's enable is 1, that direction's lines read back the driven value (`row_drv_i` or `col_drv_i`), whatever the responses are.
- R9: `sel_o[r*N+c]` is 1 when both of these hold: row r is undriven or `row_drv_i[r]`=1, and column c is undriven or `col_drv_i[c]`=1.
- R10: With `col_oe_i`=1, exactly one bit c of `col_drv_i` set and `row_oe_i`=0, bit r of `row_lines_o` equals `resp_i[r*N+c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_i | input | N*N | Element response bits, bit r*N+c for row r, column c |
| row_oe_i | input | 1 | 1: controller drives the row lines |
| row_drv_i | input | N | Value driven onto the row lines |
| col_oe_i | input | 1 | 1: controller drives the column lines |
| col_drv_i | input | N | Value driven onto the column lines |
| row_lines_o | output | N | Value read from the row lines |
| col_lines_o | output | N | Value read from the column lines |
| sel_o | output | N*N | Per-element select from the mask lines |
| any_o | output | 1 | Registered some/none flag |
| count_o | output | clog2(N*N+1) | Registered responder count |
| first_addr_o | output | clog2(N*N)+1 | Registered signed lowest responder address, -1 if none |

## Verification
The bench builds the unit with N=4, which gives a 16-element grid. At that size every one of the 65,536 response patterns can be applied on consecutive cycles. Each pattern is checked for count, flag, lowest address and row priority against arithmetic in the bench. Alongside the sweep, a changing pseudo-random mask setting exercises every combination of driven and undriven directions. A directed pass then reads back each single column on the row lines for a set of patterns.

// File: rtl/resp_pkg.sv
package resp_pkg;
  // Bits needed to hold the values 0..n inclusive.
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction

  // Signed address width: index bits plus one sign bit so -1 fits.
  function automatic int addr_bits(input int n);
    return $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/resp_prio_enc.sv
module resp_prio_enc #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  // Lowest set index wins; scan from the top so the last hit is the lowest.
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign valid_o = |vec_i;

  // No set bit may sit below the chosen index (R5 / R3 ordering).
  always_comb begin
    if (valid_o) begin
      assert_lowest_pick_R5: assert (vec_i[idx_o] && ((vec_i & ~({W{1'b1}} << idx_o)) == '0));
    end
  end
endmodule

// File: rtl/resp_popcount.sv
module resp_popcount #(
  parameter int NB = 256,
  parameter int CW = $clog2(NB + 1)
) (
  input  logic [NB-1:0] bits_i,
  output logic [CW-1:0] count_o
);
  localparam int LV = $clog2(NB);
  localparam int P  = 1 << LV;

  logic [LV:0][P-1:0][CW-1:0] lvl;

  // Binary adder tree: level 0 holds padded leaves, each level halves.
  always_comb begin
    lvl = '0;
    for (int i = 0; i < NB; i++) lvl[0][i] = CW'(bits_i[i]);
    for (int l = 0; l < LV; l++) begin
      for (int j = 0; j < (P >> (l + 1)); j++) begin
        lvl[l+1][j] = lvl[l][2*j] + lvl[l][2*j+1];
      end
    end
  end

  assign count_o = lvl[LV][0];

  always_comb begin
    assert_count_range_R2: assert (count_o <= CW'(NB));
  end
endmodule

// File: rtl/resp_mask_lines.sv
module resp_mask_lines #(
  parameter int N = 16
) (
  input  logic [N*N-1:0] resp_i,
  input  logic           row_oe_i,
  input  logic [N-1:0]   row_drv_i,
  input  logic           col_oe_i,
  input  logic [N-1:0]   col_drv_i,
  output logic [N*N-1:0] sel_o,
  output logic [N-1:0]   row_lines_o,
  output logic [N-1:0]   col_lines_o
);
  logic [N-1:0]   row_en;
  logic [N-1:0]   col_en;
  logic [N*N-1:0] gated;
  logic [N-1:0]   row_wor;
  logic [N-1:0]   col_wor;

  // An undriven direction leaves every line of it enabled.
  assign row_en = row_oe_i ? row_drv_i : '1;
  assign col_en = col_oe_i ? col_drv_i : '1;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign sel_o[r*N+c] = row_en[r] & col_en[c];
      assign gated[r*N+c] = resp_i[r*N+c] & sel_o[r*N+c];
    end
    assign row_wor[r] = |gated[r*N +: N];
  end

  for (genvar c = 0; c < N; c++) begin : g_colwor
    logic [N-1:0] colbits;
    for (genvar r = 0; r < N; r++) begin : g_pick
      assign colbits[r] = gated[r*N+c];
    end
    assign col_wor[c] = |colbits;
  end

  // Driven lines read back the drive; undriven lines read the wired-OR.
  assign row_lines_o = row_oe_i ? row_drv_i : row_wor;
  assign col_lines_o = col_oe_i ? col_drv_i : col_wor;
endmodule

// File: rtl/resp_resolver.sv
module resp_resolver
  import resp_pkg::*;
#(
  parameter int N  = 16,
  parameter int NE = N * N,
  parameter int CW = cnt_bits(N * N),
  parameter int AW = addr_bits(N * N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N*N-1:0]       resp_i,
  input  logic                 row_oe_i,
  input  logic [N-1:0]         row_drv_i,
  input  logic                 col_oe_i,
  input  logic [N-1:0]         col_drv_i,
  output logic [N-1:0]         row_lines_o,
  output logic [N-1:0]         col_lines_o,
  output logic [N*N-1:0]       sel_o,
  output logic                 any_o,
  output logic [CW-1:0]        count_o,
  output logic signed [AW-1:0] first_addr_o
);
  localparam int RW = $clog2(N);
  localparam int IW = AW - 1;

  logic [N-1:0]         row_any;
  logic [RW-1:0]        row_idx;
  logic                 row_hit;
  logic [N-1:0]         row_bits;
  logic [RW-1:0]        col_idx;
  logic                 col_hit;
  logic                 any_nxt;
  logic [CW-1:0]        count_nxt;
  logic signed [AW-1:0] addr_nxt;

  // Stage 1: per-row OR feeds the row priority encoder.
  for (genvar r = 0; r < N; r++) begin : g_rowany
    assign row_any[r] = |resp_i[r*N +: N];
  end

  resp_prio_enc #(.W(N), .IW(RW)) u_row_enc (
    .vec_i   (row_any),
    .idx_o   (row_idx),
    .valid_o (row_hit)
  );

  // Stage 2: only the winning row reaches the column encoder.
  assign row_bits = resp_i[int'(row_idx)*N +: N];

  resp_prio_enc #(.W(N), .IW(RW)) u_col_enc (
    .vec_i   (row_bits),
    .idx_o   (col_idx),
    .valid_o (col_hit)
  );

  resp_popcount #(.NB(NE), .CW(CW)) u_count (
    .bits_i  (resp_i),
    .count_o (count_nxt)
  );

  resp_mask_lines #(.N(N)) u_lines (
    .resp_i      (resp_i),
    .row_oe_i    (row_oe_i),
    .row_drv_i   (row_drv_i),
    .col_oe_i    (col_oe_i),
    .col_drv_i   (col_drv_i),
    .sel_o       (sel_o),
    .row_lines_o (row_lines_o),
    .col_lines_o (col_lines_o)
  );

  // Next-state for the registered results.
  always_comb begin
    any_nxt = |resp_i;
    if (row_hit && col_hit) begin
      addr_nxt = AW'(IW'(row_idx) * IW'(N) + IW'(col_idx));
    end else begin
      addr_nxt = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_o        <= 1'b0;
      count_o      <= '0;
      first_addr_o <= '1;
    end else begin
      any_o        <= any_nxt;
      count_o      <= count_nxt;
      first_addr_o <= addr_nxt;
    end
  end

  // Flag and count come from separate logic and must agree.
  assert_any_count_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_o == (count_o != '0));

  assert_none_is_minus_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_o |-> (first_addr_o == '1));

  assert_first_is_responder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> |($past(resp_i) & ({{(NE-1){1'b0}}, 1'b1} << first_addr_o[IW-1:0])));

  assert_quiet_input_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(resp_i) == '0) |-> (count_o == '0 && first_addr_o == '1));

  assert_single_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (row_oe_i && col_oe_i && $onehot(row_drv_i) && $onehot(col_drv_i)) |-> $onehot(sel_o));
endmodule

// File: tb/resp_resolver_tb_top.sv
`timescale 1ns/1ps
module resp_resolver_tb_top;
  localparam int N  = 4;
  localparam int NE = N * N;
  localparam int CW = $clog2(NE + 1);
  localparam int AW = $clog2(NE) + 1;

  logic                 clk;
  logic                 rst_n;
  logic [NE-1:0]        resp;
  logic                 row_oe;
  logic [N-1:0]         row_drv;
  logic                 col_oe;
  logic [N-1:0]         col_drv;
  logic [N-1:0]         row_lines;
  logic [N-1:0]         col_lines;
  logic [NE-1:0]        sel;
  logic                 any;
  logic [CW-1:0]        count;
  logic signed [AW-1:0] first_addr;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;

  resp_resolver #(.N(N)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .resp_i       (resp),
    .row_oe_i     (row_oe),
    .row_drv_i    (row_drv),
    .col_oe_i     (col_oe),
    .col_drv_i    (col_drv),
    .row_lines_o  (row_lines),
    .col_lines_o  (col_lines),
    .sel_o        (sel),
    .any_o        (any),
    .count_o      (count),
    .first_addr_o (first_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ones(input logic [NE-1:0] p);
    int n = 0;
    for (int i = 0; i < NE; i++) n += int'(p[i]);
    return n;
  endfunction

  function automatic int lowest(input logic [NE-1:0] p);
    for (int i = 0; i < NE; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic int first_row(input logic [NE-1:0] p);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) if (p[r*N+c]) return r;
    return -1;
  endfunction

  // Registered results for the pattern applied one clock earlier.
  task automatic check_regs(input logic [NE-1:0] p);
    int fa = int'(first_addr);
    check(any == (p != '0), "R1 any flag", int'(any), int'(p != '0));
    check(int'(count) == ones(p), "R2 count", int'(count), ones(p));
    check(fa == lowest(p), "R3 first address", fa, lowest(p));
    if (p != '0) begin
      check(fa >= 0 && fa < NE && p[fa[$clog2(NE)-1:0]], "R4 address maps to responder", fa, lowest(p));
      check(fa / N == first_row(p), "R5 row priority", fa / N, first_row(p));
    end
  endtask

  // Combinational mask-line results for the current inputs.
  task automatic check_lines(input logic [NE-1:0] p);
    logic [N-1:0]  ren, cen, er, ec;
    logic [NE-1:0] es;
    ren = row_oe ? row_drv : '1;
    cen = col_oe ? col_drv : '1;
    er = '0; ec = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        es[r*N+c] = ren[r] & cen[c];
        if (es[r*N+c] && p[r*N+c]) begin er[r] = 1'b1; ec[c] = 1'b1; end
      end
    if (row_oe) er = row_drv;
    if (col_oe) ec = col_drv;
    check(sel == es, "R9 select", int'(sel), int'(es));
    check(row_lines == er, row_oe ? "R8 driven rows" : "R7 row wired-OR", int'(row_lines), int'(er));
    check(col_lines == ec, col_oe ? "R8 driven cols" : "R7 col wired-OR", int'(col_lines), int'(ec));
  endtask

  initial begin
    logic [31:0]   lfsr = 32'h1234_5678;
    logic [NE-1:0] prev = '0;
    rst_n = 1'b0; resp = '1; row_oe = 1'b0; col_oe = 1'b0; row_drv = '0; col_drv = '0;
    repeat (3) @(negedge clk);
    // R6: reset values even with responders present.
    check(any == 1'b0, "R6 reset any", int'(any), 0);
    check(count == '0, "R6 reset count", int'(count), 0);
    check(int'(first_addr) == -1, "R6 reset address", int'(first_addr), -1);
    rst_n = 1'b1;

    for (int k = 0; k < (1 << NE); k++) begin
      @(negedge clk);
      if (k > 0) check_regs(prev);
      resp = NE'(k);
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      row_oe  = lfsr[20];
      col_oe  = lfsr[23];
      row_drv = lfsr[27:24];
      col_drv = lfsr[31:28];
      #1;
      check_lines(resp);
      prev = resp;
    end
    @(negedge clk);
    check_regs(prev);

    // R10: read one whole column on the row lines.
    for (int t = 0; t < 8; t++) begin
      resp = NE'(16'hA5C3 ^ (16'h1357 * t));
      row_oe = 1'b0;
      col_oe = 1'b1;
      for (int c = 0; c < N; c++) begin
        logic [N-1:0] ecol;
        col_drv = N'(1) << c;
        #1;
        for (int r = 0; r < N; r++) ecol[r] = resp[r*N+c];
        check(row_lines == ecol, "R10 column read", int'(row_lines), int'(ecol));
      end
    end

    // R6: one-cycle latency back to empty after a full grid.
    @(negedge clk);
    resp = '1;
    @(negedge clk);
    resp = '0;
    check(int'(count) == NE, "R6 latency full", int'(count), NE);
    @(negedge clk);
    check(int'(count) == 0 && int'(first_addr) == -1, "R6 latency empty", int'(count), 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule